// File: doc/BRIEF.md
# Precomputed Magnitude Comparator

This block takes a stream of unsigned operand pairs and, for each pair, reports whether the first operand is strictly greater than the second. It saves switching by storing the two top bits in a small register that loads on every accepted pair. The remaining low-order bits go into a wider register that is only loaded when the top bits cannot decide the result on their own. When the top bits differ, the wide register keeps its old contents. The result is then the top bit of the first operand.

Operands arrive on a valid/ready stream and results leave on another. There is one register stage, so a pair accepted on one clock edge appears at the output from that edge on. The pipeline moves when the output slot is empty or is being drained. If the consumer holds `out_ready` low while `out_valid` is high, the result stays put and `in_ready` drops, so no new pair enters until that result has been taken. A saturating counter records how many accepted pairs skipped the wide load. Power estimation can read it. The stored low-order bits are also brought out, so the held state can be observed.

Top module: `precomp_cmp`

## Requirements
- R1: During and right after a synchronous active-low reset, `out_valid`, `out_gt`, `lo_hold` and `gate_count` are all zero.
- R2: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. From that edge on, `out_valid` is 1 and `out_gt` equals the unsigned comparison `in_a > in_b` of the accepted pair.
- R3: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_gt` does not change.
- R5: If an accepted pair has differing top bits (bit W-1), `lo_hold` keeps its previous value.
- R6: If an accepted pair has equal top bits, `lo_hold` becomes `{in_a[W-2:0], in_b[W-2:0]}`, with the first operand's low bits in the upper half.
- R7: `gate_count` rises by one for each accepted pair with differing top bits, and holds at 2^CW-1 once it gets there.
- R8: When a result is drained (`out_valid` and `out_ready` high) and no new pair is accepted on that edge, `out_valid` is low afterwards.
- R9: Equal operands give `out_gt` = 0. This holds both when the top bits are set and when they are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | W | First operand, unsigned |
| in_b | input | W | Second operand, unsigned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_gt | output | 1 | 1 when first operand > second operand |
| lo_hold | output | 2*(W-1) | Contents of the gated low-bit register |
| gate_count | output | CW | Saturating count of skipped wide loads |

## Verification
Draining a result and accepting a new pair can happen on the same edge. On such an edge, the new pair may have differing top bits, so the wide register stays frozen and the counter steps, while the output switches to a result that comes only from the top bits. Random stimulus drives `out_ready` high often while `in_valid` stays asserted, which provokes these overlaps. Long stalls alternate with these bursts. A reference model then judges `out_gt`, `lo_hold` and `gate_count` on every cycle against the full-width comparison and the load rule.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  // Top bits that differ decide the comparison alone; the wide load is skipped.
  function automatic logic skip_low(input logic a_top, input logic b_top);
    return a_top ^ b_top;
  endfunction
endpackage

// File: rtl/pcmp_hold_reg.sv
module pcmp_hold_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pcmp_decide.sv
module pcmp_decide #(
  parameter int LW = 15
) (
  input  logic          a_top,
  input  logic          b_top,
  input  logic [LW-1:0] a_low,
  input  logic [LW-1:0] b_low,
  output logic          gt
);
  // Ripple from LSB upwards: each stage overrides if its bits differ.
  logic [LW:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < LW; i++) begin : g_bit
    assign chain[i+1] = (a_low[i] ^ b_low[i]) ? a_low[i] : chain[i];
  end
  assign gt = pcmp_pkg::skip_low(a_top, b_top) ? a_top : chain[LW];
endmodule

// File: rtl/pcmp_sat_counter.sv
module pcmp_sat_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = '1;
  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/precomp_cmp.sv
module precomp_cmp #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_gt,
  output logic [2*W-3:0]    lo_hold,
  output logic [CW-1:0]     gate_count
);
  localparam int LW = W - 1;

  logic       accept;
  logic       skip;
  logic [1:0] top_q;
  logic       valid_q;

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign skip     = pcmp_pkg::skip_low(in_a[W-1], in_b[W-1]);

  pcmp_hold_reg #(.W(2)) u_top (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .d({in_a[W-1], in_b[W-1]}), .q(top_q)
  );

  pcmp_hold_reg #(.W(2*LW)) u_low (
    .clk(clk), .rst_n(rst_n), .load(accept && !skip),
    .d({in_a[LW-1:0], in_b[LW-1:0]}), .q(lo_hold)
  );

  pcmp_decide #(.LW(LW)) u_dec (
    .a_top(top_q[1]), .b_top(top_q[0]),
    .a_low(lo_hold[2*LW-1:LW]), .b_low(lo_hold[LW-1:0]),
    .gt(out_gt)
  );

  pcmp_sat_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(accept && skip), .count(gate_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (accept)    valid_q <= 1'b1;
    else if (out_ready) valid_q <= 1'b0;
  end
  assign out_valid = valid_q;
endmodule

// File: rtl/pcmp_checker.sv
module pcmp_checker #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_gt,
  input logic [2*W-3:0] lo_hold,
  input logic [CW-1:0]  gate_count
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && (out_gt == $past(in_a > in_b)));
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_gt));
  // R5
  low_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_a[W-1] != in_b[W-1])) |=> $stable(lo_hold));
  // R6
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_a[W-1] == in_b[W-1])) |=> lo_hold == $past({in_a[W-2:0], in_b[W-2:0]}));
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gate_count == $past(gate_count)) || (gate_count == $past(gate_count) + 1'b1));
  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind precomp_cmp pcmp_checker #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_gt(out_gt), .lo_hold(lo_hold), .gate_count(gate_count)
);

// File: tb/tb_precomp_cmp.sv
module tb_precomp_cmp;
  localparam int W  = 16;
  localparam int CW = 8;
  localparam int LW = W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid, out_gt;
  logic [2*W-3:0] lo_hold;
  logic [CW-1:0] gate_count;

  int checks = 0, errors = 0;
  logic e_valid = 1'b0, e_gt = 1'b0;
  logic [2*W-3:0] e_lo = '0;
  logic [CW-1:0] e_cnt = '0;

  always #5 clk = ~clk;

  precomp_cmp #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_gt(out_gt), .lo_hold(lo_hold), .gate_count(gate_count)
  );

  function automatic logic ref_gt(input logic [W-1:0] a, input logic [W-1:0] b);
    return a > b;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare outputs with the model at the falling edge.
  task automatic check_outputs(input string tag);
    check({tag, " R2/R4/R8 out_valid"}, 64'(out_valid), 64'(e_valid));
    if (e_valid) check({tag, " R2/R9 out_gt"}, 64'(out_gt), 64'(e_gt));
    check({tag, " R5/R6 lo_hold"}, 64'(lo_hold), 64'(e_lo));
    check({tag, " R7 gate_count"}, 64'(gate_count), 64'(e_cnt));
  endtask

  // Drive one cycle of stimulus and advance the model across the next edge.
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input logic rdy);
    logic acc;
    @(negedge clk);
    check_outputs("cyc");
    in_valid = v; in_a = a; in_b = b; out_ready = rdy;
    #1;
    acc = v && (!e_valid || rdy);
    check("R3 in_ready", 64'(in_ready), 64'(!e_valid || rdy));
    if (acc) begin
      e_valid = 1'b1;
      e_gt = ref_gt(a, b);
      if (a[W-1] == b[W-1]) e_lo = {a[LW-1:0], b[LW-1:0]};
      else if (e_cnt != '1) e_cnt = e_cnt + 1'b1;
    end else if (rdy) begin
      e_valid = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 out_gt", 64'(out_gt), 64'd0);
    check("R1 lo_hold", 64'(lo_hold), 64'd0);
    check("R1 gate_count", 64'(gate_count), 64'd0);
    rst_n = 1'b1;

    // R9 equal operands, top bits set and clear
    step(1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    step(1'b1, 16'h1234, 16'h1234, 1'b1);
    // R6 equal tops, low bits decide
    step(1'b1, 16'h0005, 16'h0004, 1'b1);
    // R5 differing tops with opposite low bits
    step(1'b1, 16'h8000, 16'h7FFF, 1'b1);
    step(1'b1, 16'h7FFF, 16'h8000, 1'b1);
    // R4 stall then release
    step(1'b1, 16'h0001, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 16'h0000, 1'b1);
    // R8 drain with no input
    step(1'b0, 16'h0000, 16'h0000, 1'b1);
    step(1'b0, 16'h0000, 16'h0000, 1'b1);

    // Random phases with different back-pressure levels; R7 saturates
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        logic [W-1:0] a, b;
        logic v, r;
        a = W'($urandom);
        b = W'($urandom);
        if (($urandom % 4) == 0) b = a;
        if (($urandom % 3) == 0) b[W-1] = a[W-1];
        v = (($urandom % 8) < 6);
        r = (($urandom % 4) <= ph) || (ph == 3);
        step(v, a, b, r);
      end
    end
    step(1'b0, '0, '0, 1'b1);
    @(negedge clk);
    check_outputs("end");
    check("R7 saturated", 64'(gate_count), 64'(8'hFF));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule